// File: doc/BRIEF.md
# Priority-Resolved Pin Function Selector

This block chooses what drives each of a small group of multi-function pads. Every pad can carry up to five ranked candidate signals plus one fallback signal. A candidate is enabled by one or more enabling terms that are ORed together. Each term is an AND of field comparisons, and those fields may come from any of several control registers or from a read-only strap word. The highest-ranked candidate with a true term wins. If no candidate is enabled, the pad carries its fallback signal.

Software reaches the control registers through a plain write and read port. The strap word comes from a chip-level input and is visible at its own offset. Each pad's winning slot is shown as a one-hot vector. The output value and output-enable of the winning slot are passed through to the pad.

The pads and their selection terms are held in a constant descriptor table in the package. The selection logic is generated from that table. Slot k (k = 0 to 4) of a pad is rank k, where rank 0 is the highest. Slot 5 is the fallback. The select bit for pad p and slot s sits at position p*6+s.

Top module: `pinmux_prio_top`

## Requirements
- R1: After reset, every control register reads zero. With a strap of zero, pads 0, 1, 3, 4, 5 and 6 select slot 5. Pads 2 and 7 select slot 1, because their rank-1 terms compare a strap bit against zero.
- R2: For every pad, exactly one of its six select bits is set in every cycle.
- R3: A ranked slot is selected only when one of its terms is true and no higher-ranked slot of that pad has a true term.
- R4: Pad 0 takes slot 0 when offset 0x3C bit 3 = 1, offset 0x80 bit 15 = 1 and offset 0x90 bit 31 = 0. It takes slot 1 when those first two bits are 1 and 0x90 bit 31 = 1. Otherwise it takes slot 5.
- R5: Pad 1 takes slot 0 when offset 0x80 bit 12 = 1 or strap bit 14 = 1. When both are 0 it takes slot 5.
- R6: Pad 2 takes slot 0 when offset 0x80 bit 25 = 1. Otherwise it takes slot 1 when offset 0xA4 bit 12 = 1 or strap bit 19 = 0. Otherwise it takes slot 5.
- R7: The video mode field is offset 0x90 bits [5:4], where 0 means off and 1, 2 and 3 select the three bus widths. Pad 3 takes slot 0 when this field is nonzero and offset 0x84 bit 17 = 1. It takes slot 1 when the field is zero and bit 17 = 1. Otherwise it takes slot 5.
- R8: Pad 4 takes slot 0 when the mode field equals 3 and offset 0x84 bit 22 = 1, and slot 1 when bit 22 = 1 and the field is not 3. Pad 5 behaves the same way using bit 23. With its bit clear, each of these pads takes slot 5.
- R9: Pad 6 takes slot 0 when offset 0x90 bit 22 = 1. Otherwise it takes slot 1 when offset 0x80 bit 4 = 1. Otherwise it takes slot 5.
- R10: Pad 7 takes slot 0 when offset 0xA0 bit 0 = 1. Otherwise it takes slot 1 when strap bit 6 = 0. Otherwise it takes slot 5, and its fallback is a non-GPIO clock.
- R11: Writes to offsets 0x3C, 0x80, 0x84, 0x90, 0xA0 and 0xA4 are stored, and the next read returns the stored value. Offset 0x70 always reads the strap input, and writes to it change nothing. Other offsets read zero and ignore writes.
- R12: Each pad's output value and output-enable equal the value and enable inputs of its selected slot. The inputs of all other slots have no effect on the pad.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte offset |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr (combinational) |
| strap_i | input | 32 | Read-only strap word |
| slot_do_i | input | 48 | Output value per pad and slot, index p*6+s |
| slot_oe_i | input | 48 | Output enable per pad and slot, index p*6+s |
| pad_do_o | output | 8 | Output value per pad |
| pad_oe_o | output | 8 | Output enable per pad |
| sel_o | output | 48 | One-hot selected slot per pad, index p*6+s |

## Verification
Each enabling term is driven true and false on its own, and then in combination with the other terms of the same pad. This shows that a higher rank overrides a lower one, that both legs of each OR are needed, and that every AND input is needed. The video mode field is swept through all four codes. This separates the "any nonzero" compare from the "equals 3" compare on neighbouring pads that share one enable register. Strap bits are toggled both with and without a matching control bit, which separates strap-enabled terms from control-enabled terms. The register port is tried at stored offsets, at the strap offset and at an unmapped offset, and each time the pad selections are checked for side effects.

// File: rtl/pinmux_pkg.sv
package pinmux_pkg;

    localparam int NPIN    = 8;
    localparam int NLVL    = 5;
    localparam int NSLOT   = NLVL + 1;
    localparam int NEXPR   = 3;
    localparam int NDESC   = 3;
    localparam int NCTRL   = 6;
    localparam int NREG    = NCTRL + 1;
    localparam int DW      = 32;
    localparam int AW      = 8;
    localparam int RIDX_W  = $clog2(NREG);
    localparam int LSB_W   = $clog2(DW);
    localparam int FLD_W   = 2;

    // register indices into the evaluated register vector
    localparam int RI_C3C   = 0;
    localparam int RI_C80   = 1;
    localparam int RI_C84   = 2;
    localparam int RI_C90   = 3;
    localparam int RI_CA0   = 4;
    localparam int RI_CA4   = 5;
    localparam int RI_STRAP = NCTRL;

    localparam logic [AW-1:0] STRAP_OFFSET = 8'h70;

    function automatic logic [AW-1:0] ctrl_offset(int i);
        case (i)
            0:       return 8'h3C;
            1:       return 8'h80;
            2:       return 8'h84;
            3:       return 8'h90;
            4:       return 8'hA0;
            default: return 8'hA4;
        endcase
    endfunction

    // one field comparison: field at lsb (1 or 2 bits wide) must equal val
    typedef struct packed {
        logic              used;
        logic [RIDX_W-1:0] ridx;
        logic [LSB_W-1:0]  lsb;
        logic              wide;
        logic [FLD_W-1:0]  val;
    } fdesc_t;

    function automatic fdesc_t fd(int ridx, int lsb, int wide, int val);
        fdesc_t r;
        r.used = 1'b1;
        r.ridx = RIDX_W'(ridx);
        r.lsb  = LSB_W'(lsb);
        r.wide = (wide != 0);
        r.val  = FLD_W'(val);
        return r;
    endfunction

    // descriptor k of term e of rank l on pad p; unused entries are all-zero
    // a term is in use exactly when its descriptor 0 is in use
    function automatic fdesc_t desc_at(int p, int l, int e, int k);
        fdesc_t d;
        d = '0;
        case (p)
            0: if (l < 2 && e == 0) begin
                   if (k == 0) d = fd(RI_C3C, 3, 0, 1);
                   if (k == 1) d = fd(RI_C80, 15, 0, 1);
                   if (k == 2) d = fd(RI_C90, 31, 0, (l == 1) ? 1 : 0);
               end
            1: if (l == 0 && k == 0) begin
                   if (e == 0) d = fd(RI_C80, 12, 0, 1);
                   if (e == 1) d = fd(RI_STRAP, 14, 0, 1);
               end
            2: if (k == 0) begin
                   if (l == 0 && e == 0) d = fd(RI_C80, 25, 0, 1);
                   if (l == 1 && e == 0) d = fd(RI_CA4, 12, 0, 1);
                   if (l == 1 && e == 1) d = fd(RI_STRAP, 19, 0, 0);
               end
            3: begin
                   if (l == 0 && k == 0) d = fd(RI_C90, 4, 1, e + 1);
                   if (l == 0 && k == 1) d = fd(RI_C84, 17, 0, 1);
                   if (l == 1 && e == 0 && k == 0) d = fd(RI_C84, 17, 0, 1);
               end
            4, 5: if (e == 0) begin
                   if (l == 0 && k == 0) d = fd(RI_C90, 4, 1, 3);
                   if (l == 0 && k == 1) d = fd(RI_C84, (p == 4) ? 22 : 23, 0, 1);
                   if (l == 1 && k == 0) d = fd(RI_C84, (p == 4) ? 22 : 23, 0, 1);
               end
            6: if (e == 0 && k == 0) begin
                   if (l == 0) d = fd(RI_C90, 22, 0, 1);
                   if (l == 1) d = fd(RI_C80, 4, 0, 1);
               end
            7: if (e == 0 && k == 0) begin
                   if (l == 0) d = fd(RI_CA0, 0, 0, 1);
                   if (l == 1) d = fd(RI_STRAP, 6, 0, 0);
               end
            default: d = '0;
        endcase
        return d;
    endfunction

endpackage

// File: rtl/pinmux_regbank.sv
module pinmux_regbank
    import pinmux_pkg::*;
(
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      reg_we,
    input  logic [AW-1:0]             reg_addr,
    input  logic [DW-1:0]             reg_wdata,
    output logic [DW-1:0]             reg_rdata,
    input  logic [DW-1:0]             strap_i,
    output logic [NREG-1:0][DW-1:0]   regs_o
);

    logic [NCTRL-1:0][DW-1:0] ctrl_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
        end else if (reg_we) begin
            for (int i = 0; i < NCTRL; i++) begin
                if (reg_addr == ctrl_offset(i)) ctrl_q[i] <= reg_wdata;
            end
        end
    end

    always_comb begin
        reg_rdata = '0;
        for (int i = 0; i < NCTRL; i++) begin
            if (reg_addr == ctrl_offset(i)) reg_rdata = ctrl_q[i];
        end
        if (reg_addr == STRAP_OFFSET) reg_rdata = strap_i;
    end

    for (genvar i = 0; i < NCTRL; i++) begin : g_pack
        assign regs_o[i] = ctrl_q[i];
    end
    assign regs_o[RI_STRAP] = strap_i;

endmodule

// File: rtl/pinmux_level_eval.sv
module pinmux_level_eval
    import pinmux_pkg::*;
#(
    parameter int PIN = 0,
    parameter int LVL = 0
) (
    input  logic [NREG-1:0][DW-1:0] regs_i,
    output logic                    hit_o
);

    logic [NEXPR-1:0] term_true;

    for (genvar e = 0; e < NEXPR; e++) begin : g_term
        localparam fdesc_t HEAD = desc_at(PIN, LVL, e, 0);
        logic [NDESC-1:0] cmp_ok;

        for (genvar k = 0; k < NDESC; k++) begin : g_desc
            localparam fdesc_t D = desc_at(PIN, LVL, e, k);
            if (!D.used) begin : g_none
                assign cmp_ok[k] = 1'b1;
            end else if (D.wide) begin : g_wide
                assign cmp_ok[k] = (regs_i[D.ridx][D.lsb +: FLD_W] == D.val);
            end else begin : g_bit
                assign cmp_ok[k] = ({1'b0, regs_i[D.ridx][D.lsb]} == D.val);
            end
        end

        if (HEAD.used) begin : g_live
            assign term_true[e] = &cmp_ok;
        end else begin : g_dead
            assign term_true[e] = 1'b0;
        end
    end

    assign hit_o = |term_true;

    // most register bits feed no term of this rank
    logic unused_regs;
    assign unused_regs = ^regs_i;

endmodule

// File: rtl/pinmux_prio_pick.sv
module pinmux_prio_pick
    import pinmux_pkg::*;
(
    input  logic [NLVL-1:0]  hit_i,
    output logic [NSLOT-1:0] sel_o
);

    logic [NLVL:0] above;

    always_comb begin
        above[0] = 1'b0;
        for (int l = 0; l < NLVL; l++) begin
            sel_o[l]     = hit_i[l] & ~above[l];
            above[l + 1] = above[l] | hit_i[l];
        end
        sel_o[NLVL] = ~above[NLVL];
    end

endmodule

// File: rtl/pinmux_prio_top.sv
module pinmux_prio_top
    import pinmux_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   reg_we,
    input  logic [AW-1:0]          reg_addr,
    input  logic [DW-1:0]          reg_wdata,
    output logic [DW-1:0]          reg_rdata,
    input  logic [DW-1:0]          strap_i,
    input  logic [NPIN*NSLOT-1:0]  slot_do_i,
    input  logic [NPIN*NSLOT-1:0]  slot_oe_i,
    output logic [NPIN-1:0]        pad_do_o,
    output logic [NPIN-1:0]        pad_oe_o,
    output logic [NPIN*NSLOT-1:0]  sel_o
);

    logic [NREG-1:0][DW-1:0] regs;

    pinmux_regbank u_regs (
        .clk       (clk),
        .rst       (rst),
        .reg_we    (reg_we),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .strap_i   (strap_i),
        .regs_o    (regs)
    );

    for (genvar p = 0; p < NPIN; p++) begin : g_pad
        logic [NLVL-1:0]  hit;
        logic [NSLOT-1:0] pick;

        for (genvar l = 0; l < NLVL; l++) begin : g_lvl
            pinmux_level_eval #(.PIN(p), .LVL(l)) u_eval (
                .regs_i (regs),
                .hit_o  (hit[l])
            );
        end

        pinmux_prio_pick u_pick (
            .hit_i (hit),
            .sel_o (pick)
        );

        assign sel_o[p*NSLOT +: NSLOT] = pick;
        assign pad_do_o[p] = |(pick & slot_do_i[p*NSLOT +: NSLOT]);
        assign pad_oe_o[p] = |(pick & slot_oe_i[p*NSLOT +: NSLOT]);
    end

endmodule

// File: rtl/pinmux_prio_chk.sv
module pinmux_prio_chk
    import pinmux_pkg::*;
(
    input logic                  clk,
    input logic                  rst,
    input logic [DW-1:0]         strap_i,
    input logic [NPIN*NSLOT-1:0] slot_oe_i,
    input logic [NPIN-1:0]       pad_oe_o,
    input logic [NPIN*NSLOT-1:0] sel_o
);

    for (genvar p = 0; p < NPIN; p++) begin : g_pad
        AST_SEL_ONE_HOT: assert property (@(posedge clk) disable iff (rst)
            $countones(sel_o[p*NSLOT +: NSLOT]) == 1); // R2

        AST_OE_NEEDS_SOURCE: assert property (@(posedge clk) disable iff (rst)
            ($countones(slot_oe_i[p*NSLOT +: NSLOT]) == 0) |-> !pad_oe_o[p]); // R12
    end

    AST_RESET_FALLBACK: assert property (@(posedge clk)
        rst |=> (sel_o[0*NSLOT+NLVL] && sel_o[3*NSLOT+NLVL] && sel_o[6*NSLOT+NLVL])); // R1

    AST_STRAP_RESET_IN: assert property (@(posedge clk) disable iff (rst)
        strap_i[14] |-> sel_o[1*NSLOT+0]); // R5

    AST_STRAP_LOW_ENABLE: assert property (@(posedge clk) disable iff (rst)
        !strap_i[19] |-> !sel_o[2*NSLOT+NLVL]); // R6

    AST_ETH_FALLBACK_BLOCK: assert property (@(posedge clk) disable iff (rst)
        !strap_i[6] |-> !sel_o[7*NSLOT+NLVL]); // R10

endmodule

bind pinmux_prio_top pinmux_prio_chk u_chk (.*);

// File: tb/pinmux_prio_top_tb_top.sv
module pinmux_prio_top_tb_top;
    import pinmux_pkg::*;

    logic                  clk = 1'b0;
    logic                  rst = 1'b1;
    logic                  reg_we = 1'b0;
    logic [AW-1:0]         reg_addr = '0;
    logic [DW-1:0]         reg_wdata = '0;
    logic [DW-1:0]         reg_rdata;
    logic [DW-1:0]         strap_i = '0;
    logic [NPIN*NSLOT-1:0] slot_do_i = '0;
    logic [NPIN*NSLOT-1:0] slot_oe_i = '0;
    logic [NPIN-1:0]       pad_do_o;
    logic [NPIN-1:0]       pad_oe_o;
    logic [NPIN*NSLOT-1:0] sel_o;

    int n_checks = 0;
    int n_errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    pinmux_prio_top dut_i (.*);

    task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic chk_sel(input int pin, input int exp_slot, input string tag);
        logic [NSLOT-1:0] got;
        logic [NSLOT-1:0] want;
        #1;
        got  = sel_o[pin*NSLOT +: NSLOT];
        want = NSLOT'(1) << exp_slot;
        n_checks++;
        if (got != want) begin
            n_errors++;
            $display("FAIL %s pad %0d select: actual %b expected %b", tag, pin, got, want);
        end
        n_checks++;
        if ($countones(got) != 1) begin
            n_errors++;
            $display("FAIL R2 pad %0d select not one-hot: actual %b expected one bit", pin, got);
        end
    endtask

    task automatic chk_rd(input logic [AW-1:0] a, input logic [DW-1:0] exp, input string tag);
        reg_addr = a;
        #1;
        n_checks++;
        if (reg_rdata != exp) begin
            n_errors++;
            $display("FAIL %s read 0x%02h: actual %h expected %h", tag, a, reg_rdata, exp);
        end
    endtask

    task automatic chk_bit(input logic got, input logic exp, input string tag);
        n_checks++;
        if (got !== exp) begin
            n_errors++;
            $display("FAIL %s: actual %b expected %b", tag, got, exp);
        end
    endtask

    task automatic t_reset();
        chk_rd(8'h80, 32'h0, "R1");
        chk_rd(8'h90, 32'h0, "R1");
        chk_sel(0, 5, "R1"); chk_sel(1, 5, "R1"); chk_sel(2, 1, "R1");
        chk_sel(3, 5, "R1"); chk_sel(4, 5, "R1"); chk_sel(5, 5, "R1");
        chk_sel(6, 5, "R1"); chk_sel(7, 1, "R1");
    endtask

    task automatic t_ext_reset();
        wr(8'h3C, 32'h8);
        chk_sel(0, 5, "R4");
        wr(8'h80, 32'h1 << 15);
        chk_sel(0, 0, "R4");
        wr(8'h90, 32'h1 << 31);
        chk_sel(0, 1, "R4");
        wr(8'h3C, 32'h0);
        chk_sel(0, 5, "R4");
        wr(8'h80, 32'h0); wr(8'h90, 32'h0);
    endtask

    task automatic t_reset_in();
        strap_i = 32'h1 << 14;
        chk_sel(1, 0, "R5");
        strap_i = 32'h0;
        chk_sel(1, 5, "R5");
        wr(8'h80, 32'h1 << 12);
        chk_sel(1, 0, "R5");
        wr(8'h80, 32'h0);
        chk_sel(1, 5, "R5");
    endtask

    task automatic t_pad2();
        strap_i = 32'h1 << 19;
        chk_sel(2, 5, "R6");
        wr(8'hA4, 32'h1 << 12);
        chk_sel(2, 1, "R6");
        wr(8'h80, 32'h1 << 25);
        chk_sel(2, 0, "R3");
        wr(8'h80, 32'h0);
        chk_sel(2, 1, "R3");
        wr(8'hA4, 32'h0);
        chk_sel(2, 5, "R6");
        strap_i = 32'h0;
        chk_sel(2, 1, "R6");
    endtask

    task automatic t_video();
        wr(8'h84, (32'h1 << 17) | (32'h1 << 22) | (32'h1 << 23));
        chk_sel(3, 1, "R7"); chk_sel(4, 1, "R8"); chk_sel(5, 1, "R8");
        for (int m = 1; m < 3; m++) begin
            wr(8'h90, 32'(m) << 4);
            chk_sel(3, 0, "R7"); chk_sel(4, 1, "R8"); chk_sel(5, 1, "R8");
        end
        wr(8'h90, 32'h3 << 4);
        chk_sel(3, 0, "R7"); chk_sel(4, 0, "R8"); chk_sel(5, 0, "R8");
        wr(8'h84, 32'h1 << 22);
        chk_sel(3, 5, "R7"); chk_sel(4, 0, "R8"); chk_sel(5, 5, "R8");
        wr(8'h84, 32'h0); wr(8'h90, 32'h0);
        chk_sel(4, 5, "R8");
    endtask

    task automatic t_i2c_timer();
        wr(8'h80, 32'h1 << 4);
        chk_sel(6, 1, "R9");
        wr(8'h90, 32'h1 << 22);
        chk_sel(6, 0, "R9");
        wr(8'h80, 32'h0);
        chk_sel(6, 0, "R9");
        wr(8'h90, 32'h0);
        chk_sel(6, 5, "R9");
    endtask

    task automatic t_eth();
        strap_i = 32'h1 << 6;
        chk_sel(7, 5, "R10");
        wr(8'hA0, 32'h1);
        chk_sel(7, 0, "R10");
        strap_i = 32'h0;
        chk_sel(7, 0, "R10");
        wr(8'hA0, 32'h0);
        chk_sel(7, 1, "R10");
    endtask

    task automatic t_regs();
        wr(8'h84, 32'hDEAD_BEEF);
        chk_rd(8'h84, 32'hDEAD_BEEF, "R11");
        wr(8'h84, 32'h0);
        strap_i = 32'h0;
        wr(8'h70, 32'hFFFF_FFFF);
        chk_rd(8'h70, 32'h0, "R11");
        chk_sel(1, 5, "R11");
        strap_i = 32'h1234_5678;
        chk_rd(8'h70, 32'h1234_5678, "R11");
        strap_i = 32'h0;
        wr(8'h44, 32'hFFFF_FFFF);
        chk_rd(8'h44, 32'h0, "R11");
        chk_sel(0, 5, "R11"); chk_sel(6, 5, "R11");
        chk_rd(8'h80, 32'h0, "R11");
    endtask

    task automatic t_pad_route();
        wr(8'h80, 32'h1 << 4);
        slot_do_i = '0; slot_oe_i = '0;
        slot_do_i[6*NSLOT+1] = 1'b1;
        slot_oe_i[6*NSLOT+1] = 1'b1;
        #1;
        chk_bit(pad_do_o[6], 1'b1, "R12 pad 6 value from slot 1");
        chk_bit(pad_oe_o[6], 1'b1, "R12 pad 6 enable from slot 1");
        chk_bit(pad_do_o[0], 1'b0, "R12 pad 0 value");
        slot_do_i = '1; slot_oe_i = '1;
        slot_do_i[6*NSLOT+1] = 1'b0;
        slot_oe_i[6*NSLOT+1] = 1'b0;
        #1;
        chk_bit(pad_do_o[6], 1'b0, "R12 pad 6 ignores other slots");
        chk_bit(pad_oe_o[6], 1'b0, "R12 pad 6 enable ignores other slots");
        chk_bit(pad_do_o[0], 1'b1, "R12 pad 0 from fallback");
        slot_do_i = '0; slot_oe_i = '0;
        wr(8'h80, 32'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_ext_reset();
        t_reset_in();
        t_pad2();
        t_video();
        t_i2c_timer();
        t_eth();
        t_regs();
        t_pad_route();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin
        #(200000 * 10);
        if (!done) begin
            done = 1'b1;
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

endmodule